// File: doc/BRIEF.md
# Maskable Interrupt Request Controller

This block collects interrupt requests from six sources into a request register, gates them through a mask register that also carries a global enable, and picks one pending source for service. It gives the instruction sequencer the index of the chosen source and the address of that source's two-byte entry in the vector table at the bottom of program memory. The sequencer acknowledges the interrupt, and the block then retires the request and turns the global enable off. Pushing the return state onto the stack is left to another block.

A request bit latches whenever its source fires, even while that source is masked. Software can therefore poll the request register instead of taking vectored interrupts. Software can also write the request register to raise or retire requests itself. A priority register places each source in a high or a low class. The vector table fills the first `NUM_SRC * VEC_BYTES` bytes of program memory, so execution after reset begins just past it, at 0x000C with the default parameters.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the request, mask and priority registers read 0, `intPending` is 0, and `bootAddr` is 0x000C (six sources times two bytes).
- R2: A 1 on `srcPulse[k]` at a clock edge sets request bit k at that edge, whatever the mask bits hold.
- R3: The registers are read combinationally on `regRdData` through `regSel`, with 0 selecting the mask register, 1 the request register, 2 the priority register and 3 reading zero. Request bits k sit at bit position k, so pending requests can be polled.
- R4: `intPending` is 1 only when mask bit 7 (the global enable) is 1 and at least one source k has both request bit k and mask bit k set.
- R5: Priority bit k = 1 puts source k in the high class. A pending enabled high-class source wins over every low-class source, and within one class the lower-numbered source wins.
- R6: While `intPending` is 1, `srcId` gives the chosen source k and `vecAddr` equals 2k.
- R7: `intAck` with `intPending` = 1 clears the chosen source's request bit and mask bit 7 at that edge, and leaves the other request bits unchanged.
- R8: A write to the request register (`regWrEn` = 1, `regSel` = 1) loads `regWrData[5:0]`, so writing 1 raises a request from software and writing 0 retires it. A source firing at the same edge still sets its bit.
- R9: `intAck` while `intPending` = 0 changes no register.
- R10: Mask bit 6 and priority and request bits 7:6 always read 0, whatever value was written.
- R11: If source k fires at the same edge that acknowledges source k, request bit k stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| srcPulse | input | 6 | Per-source trigger, sampled every edge |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 mask, 1 request, 2 priority |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the selected register |
| intAck | input | 1 | Sequencer acknowledge of the presented interrupt |
| intPending | output | 1 | An enabled request is waiting |
| srcId | output | 3 | Index of the chosen source |
| vecAddr | output | 16 | Program address of the chosen vector entry |
| bootAddr | output | 16 | First program address past the vector table |

## Verification
Register updates from triggers, writes and acknowledges appear on the outputs one edge after the stimulus. `intPending`, `srcId`, `vecAddr` and `regRdData` are combinational from the registers and `regSel`. The bench drives each stimulus for exactly one rising edge, returns the inputs to idle one nanosecond after that edge, and compares every output at the following falling edge against a bench model updated at the same edge. Because the model is unchanged during idle edges, a check may sit any whole number of cycles after its stimulus.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int IRQ_SRC = 6;

  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_REQ  = 2'd1,
    SEL_PRIO = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  // strobes from selection control to the register datapath
  typedef struct packed {
    logic [IRQ_SRC-1:0] clrReq;
    logic               clrGlobal;
  } ctrlStrobe_t;
endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_pkg::*;
#(
  parameter int NUM_SRC = IRQ_SRC,
  parameter int REG_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcPulse,
  input  logic               wrEn,
  input  regSel_e            sel,
  input  logic [REG_W-1:0]   wrData,
  input  ctrlStrobe_t        strobe,
  output logic [REG_W-1:0]   rdData,
  output logic [NUM_SRC-1:0] reqQ,
  output logic [NUM_SRC-1:0] maskQ,
  output logic [NUM_SRC-1:0] prioQ,
  output logic               gieQ
);
  localparam logic [REG_W-1:0] SRC_KEEP  = REG_W'((1 << NUM_SRC) - 1);
  localparam logic [REG_W-1:0] GIE_BIT   = REG_W'(1) << (REG_W - 1);
  localparam logic [REG_W-1:0] MASK_KEEP = SRC_KEEP | GIE_BIT;

  logic [REG_W-1:0] reqReg, maskReg, prioReg;
  logic [REG_W-1:0] trigW, clrW;

  assign trigW = REG_W'(srcPulse);
  assign clrW  = REG_W'(strobe.clrReq);

  // request register: a trigger always wins over write or acknowledge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      reqReg <= '0;
    else if (wrEn && sel == SEL_REQ)
      reqReg <= (wrData & SRC_KEEP) | trigW;
    else
      reqReg <= (reqReg & ~clrW) | trigW;
  end

  // mask register, global enable in the top bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      maskReg <= '0;
    else if (wrEn && sel == SEL_MASK)
      maskReg <= wrData & MASK_KEEP;
    else if (strobe.clrGlobal)
      maskReg <= maskReg & ~GIE_BIT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      prioReg <= '0;
    else if (wrEn && sel == SEL_PRIO)
      prioReg <= wrData & SRC_KEEP;
  end

  always_comb begin
    unique case (sel)
      SEL_MASK: rdData = maskReg;
      SEL_REQ:  rdData = reqReg;
      SEL_PRIO: rdData = prioReg;
      default:  rdData = '0;
    endcase
  end

  assign reqQ  = reqReg[NUM_SRC-1:0];
  assign maskQ = maskReg[NUM_SRC-1:0];
  assign prioQ = prioReg[NUM_SRC-1:0];
  assign gieQ  = maskReg[REG_W-1];
endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_pkg::*;
#(
  parameter int NUM_SRC   = IRQ_SRC,
  parameter int VEC_BYTES = 2,
  parameter int ADDR_W    = 16,
  parameter int ID_W      = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] reqQ,
  input  logic [NUM_SRC-1:0] maskQ,
  input  logic [NUM_SRC-1:0] prioQ,
  input  logic               gieQ,
  input  logic               intAck,
  output logic               intPending,
  output logic [ID_W-1:0]    srcId,
  output logic [ADDR_W-1:0]  vecAddr,
  output ctrlStrobe_t        strobe
);
  logic [NUM_SRC-1:0] live, hiSet, loSet, pickSet, clrVec;
  logic               ackFire;

  assign live    = reqQ & maskQ;
  assign hiSet   = live & prioQ;
  assign loSet   = live & ~prioQ;
  assign pickSet = (|hiSet) ? hiSet : loSet;

  // lowest-numbered member of the winning class
  always_comb begin
    srcId = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (pickSet[i]) srcId = ID_W'(i);
  end

  assign intPending = gieQ && (|live);
  assign vecAddr    = ADDR_W'(srcId) * ADDR_W'(VEC_BYTES);
  assign ackFire    = intAck && intPending;

  for (genvar g = 0; g < NUM_SRC; g++) begin : gClr
    assign clrVec[g] = ackFire && (srcId == ID_W'(g));
  end

  always_comb begin
    strobe.clrReq    = clrVec;
    strobe.clrGlobal = ackFire;
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC   = IRQ_SRC,
  parameter int REG_W     = 8,
  parameter int VEC_BYTES = 2,
  parameter int ADDR_W    = 16,
  parameter int ID_W      = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcPulse,
  input  logic               regWrEn,
  input  logic [1:0]         regSel,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  input  logic               intAck,
  output logic               intPending,
  output logic [ID_W-1:0]    srcId,
  output logic [ADDR_W-1:0]  vecAddr,
  output logic [ADDR_W-1:0]  bootAddr
);
  localparam logic [ADDR_W-1:0] TABLE_END = ADDR_W'(NUM_SRC * VEC_BYTES);

  ctrlStrobe_t        strobe;
  logic [NUM_SRC-1:0] reqQ, maskQ, prioQ;
  logic               gieQ;

  irq_regfile #(.NUM_SRC(NUM_SRC), .REG_W(REG_W)) uRegs (
    .clk(clk), .rstN(rstN), .srcPulse(srcPulse), .wrEn(regWrEn),
    .sel(regSel_e'(regSel)), .wrData(regWrData), .strobe(strobe),
    .rdData(regRdData), .reqQ(reqQ), .maskQ(maskQ), .prioQ(prioQ), .gieQ(gieQ)
  );

  irq_select #(.NUM_SRC(NUM_SRC), .VEC_BYTES(VEC_BYTES), .ADDR_W(ADDR_W), .ID_W(ID_W)) uSel (
    .reqQ(reqQ), .maskQ(maskQ), .prioQ(prioQ), .gieQ(gieQ), .intAck(intAck),
    .intPending(intPending), .srcId(srcId), .vecAddr(vecAddr), .strobe(strobe)
  );

  assign bootAddr = TABLE_END;
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int NUM_SRC = 6,
  parameter int ADDR_W  = 16,
  parameter int ID_W    = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcPulse,
  input logic               regWrEn,
  input logic [1:0]         regSel,
  input logic               intAck,
  input logic               intPending,
  input logic [ID_W-1:0]    srcId,
  input logic [ADDR_W-1:0]  vecAddr,
  input logic [ADDR_W-1:0]  bootAddr,
  input logic [NUM_SRC-1:0] reqQ,
  input logic [NUM_SRC-1:0] maskQ,
  input logic [NUM_SRC-1:0] prioQ,
  input logic               gieQ
);
  AST_TRIG_LATCHES: assert property (@(posedge clk) disable iff (!rstN)
    (srcPulse != '0) |=> ((reqQ & $past(srcPulse)) == $past(srcPulse))); // R2

  AST_PEND_GATED: assert property (@(posedge clk) disable iff (!rstN)
    intPending |-> (gieQ && reqQ[srcId] && maskQ[srcId])); // R4

  AST_LOW_CLASS_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (intPending && !prioQ[srcId]) |-> ((reqQ & maskQ & prioQ) == '0)); // R5

  AST_VEC_IN_TABLE: assert property (@(posedge clk) disable iff (!rstN)
    intPending |-> (vecAddr < bootAddr && !vecAddr[0])); // R6

  AST_ACK_DROPS_GIE: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && intPending && !(regWrEn && regSel == 2'd0)) |=> !gieQ); // R7

  AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && intPending && !regWrEn && !srcPulse[srcId]) |=> !reqQ[$past(srcId)]); // R7

  AST_IDLE_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !intPending && !regWrEn && srcPulse == '0) |=> (reqQ == $past(reqQ) && gieQ == $past(gieQ))); // R9
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .ID_W(ID_W)) uChk (
  .clk(clk), .rstN(rstN), .srcPulse(srcPulse), .regWrEn(regWrEn), .regSel(regSel),
  .intAck(intAck), .intPending(intPending), .srcId(srcId), .vecAddr(vecAddr),
  .bootAddr(bootAddr), .reqQ(reqQ), .maskQ(maskQ), .prioQ(prioQ), .gieQ(gieQ)
);

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] srcPulse = '0;
  logic       regWrEn = 1'b0;
  logic [1:0] regSel = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       intAck = 1'b0;
  logic       intPending;
  logic [2:0] srcId;
  logic [15:0] vecAddr, bootAddr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model of the registers
  logic [5:0] reqM = '0, maskM = '0, prioM = '0;
  logic       gieM = 1'b0;

  always #5 clk = ~clk;

  irq_vector_ctrl dut (
    .clk(clk), .rstN(rstN), .srcPulse(srcPulse), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .intAck(intAck),
    .intPending(intPending), .srcId(srcId), .vecAddr(vecAddr), .bootAddr(bootAddr)
  );

  // expected winner: high class first, then lowest index
  function automatic logic [3:0] pickRef(input logic [5:0] r, input logic [5:0] m,
                                         input logic [5:0] p, input logic g);
    logic [5:0] live = r & m;
    for (int cls = 1; cls >= 0; cls--)
      for (int i = 0; i < 6; i++)
        if (g && live[i] && p[i] == cls[0]) return {1'b1, 3'(i)};
    return 4'd0;
  endfunction

  function automatic logic [7:0] readRef(input logic [1:0] s);
    case (s)
      2'd0: return {gieM, 1'b0, maskM};
      2'd1: return {2'b00, reqM};
      2'd2: return {2'b00, prioM};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic expectAll(input string tag, input logic [1:0] s);
    logic [3:0] w;
    @(negedge clk);
    regSel = s;
    #1;
    w = pickRef(reqM, maskM, prioM, gieM);
    chk(tag, "intPending", 16'(intPending), 16'(w[3]));
    if (w[3]) begin
      chk(tag, "srcId", 16'(srcId), 16'(w[2:0]));
      chk(tag, "vecAddr", vecAddr, 16'(w[2:0]) * 16'd2);
    end
    chk(tag, "regRdData", 16'(regRdData), 16'(readRef(s)));
  endtask

  task automatic step(input logic [5:0] p, input logic w, input logic [1:0] s,
                      input logic [7:0] d, input logic a);
    logic [3:0] win;
    @(negedge clk);
    srcPulse = p; regWrEn = w; regSel = s; regWrData = d; intAck = a;
    @(posedge clk);
    win = pickRef(reqM, maskM, prioM, gieM);
    if (w && s == 2'd1) reqM = d[5:0] | p;
    else begin
      if (a && win[3]) reqM[win[2:0]] = 1'b0;
      reqM = reqM | p;
    end
    if (w && s == 2'd0) begin maskM = d[5:0]; gieM = d[7]; end
    else if (a && win[3]) gieM = 1'b0;
    if (w && s == 2'd2) prioM = d[5:0];
    #1;
    srcPulse = '0; regWrEn = 1'b0; intAck = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state and table end
    expectAll("R1", 2'd0);
    expectAll("R1", 2'd1);
    expectAll("R1", 2'd2);
    chk("R1", "bootAddr", bootAddr, 16'h000C);

    // R2 masked source still latches; R3 polled readback
    step(6'b001000, 0, 2'd0, 8'h00, 0);
    expectAll("R2", 2'd1);
    chk("R3", "poll bit3", 16'(regRdData[3]), 16'd1);
    chk("R4", "masked no pending", 16'(intPending), 16'd0);

    // R4 individual enable without global enable
    step('0, 1, 2'd0, 8'h08, 0);
    expectAll("R4", 2'd0);
    chk("R4", "gie off", 16'(intPending), 16'd0);
    step('0, 1, 2'd0, 8'h88, 0);
    expectAll("R6", 2'd0);
    chk("R6", "vec for src3", vecAddr, 16'd6);

    // R5 equal class: lower index wins; high class beats lower index
    step(6'b000010, 1, 2'd0, 8'h8A, 0);
    expectAll("R5", 2'd1);
    chk("R5", "equal class", 16'(srcId), 16'd1);
    step('0, 1, 2'd2, 8'h08, 0);
    expectAll("R5", 2'd2);
    chk("R5", "high class", 16'(srcId), 16'd3);

    // R7 acknowledge retires src3 and drops global enable
    step('0, 0, 2'd0, 8'h00, 1);
    expectAll("R7", 2'd1);
    chk("R7", "req after ack", 16'(regRdData[5:0]), 16'b000010);
    expectAll("R7", 2'd0);
    chk("R7", "gie after ack", 16'(regRdData[7]), 16'd0);

    // R9 acknowledge with nothing pending
    step('0, 0, 2'd1, 8'h00, 1);
    expectAll("R9", 2'd1);
    chk("R9", "req unchanged", 16'(regRdData), 16'h02);

    // R8 software load of the request register, R10 reserved bits
    step(6'b000100, 1, 2'd1, 8'hE1, 0);
    expectAll("R8", 2'd1);
    chk("R8", "soft request", 16'(regRdData), 16'h25);
    step('0, 1, 2'd0, 8'hFF, 0);
    expectAll("R10", 2'd0);
    chk("R10", "mask bit6", 16'(regRdData), 16'hBF);
    step('0, 1, 2'd2, 8'hC0, 0);
    expectAll("R10", 2'd2);

    // R11 trigger of the acknowledged source at the same edge
    expectAll("R11", 2'd1);
    chk("R11", "winner", 16'(srcId), 16'd0);
    step(6'b000001, 0, 2'd1, 8'h00, 1);
    expectAll("R11", 2'd1);
    chk("R11", "bit0 kept", 16'(regRdData[0]), 16'd1);

    // random traffic
    for (int n = 0; n < 600; n++) begin
      logic [5:0] p = ($urandom % 4 == 0) ? 6'($urandom) : 6'd0;
      logic       w = ($urandom % 6 == 0);
      logic [1:0] s = 2'($urandom);
      logic [7:0] d = 8'($urandom);
      logic       a = ($urandom % 3 == 0);
      if (w && s == 2'd0 && ($urandom % 2 == 0)) d[7] = 1'b1;
      step(p, w, s, d, a);
      expectAll("RAND", 2'($urandom));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule